// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Master

The block is a synchronous serial master that software drives through a small word-wide register bus. Software pushes transmit words into one data address and pops received words from that same address. A transmit queue and a receive queue sit on either side of a frame shifter. The shifter sends each word MSB first on the serial clock and data-out lines, and captures the data-in line into a matching received word.

Software sets the frame length (4 to 16 bits), the serial clock divisor and a port enable. It then polls a five-bit status word to pace its pushes and pops. Read-only identification words let a driver confirm the variant before it uses the block. The serial clock idles low. Data-out changes while the clock is low, and data-in is sampled on each rising edge.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the control words read 0 (frame field 0, enable 0), the divisor word at 0x010 reads 2 and the status word at 0x00C reads 0x03.
- R2: Word reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return 0x22, 0x10, 0x04 and 0x00.
- R3: Bits [3:0] of the word at 0x000 hold frame length minus one; values 0 to 2 give 4-bit frames.
- R4: While bit 1 of the word at 0x004 is clear, the serial clock stays low, busy reads 0 and queued transmit words are held; clearing it mid-frame abandons that frame with no received word.
- R5: Status bits at 0x00C: bit 0 transmit queue empty, bit 1 transmit queue not full, bit 2 receive queue not empty, bit 3 receive queue full, bit 4 busy.
- R6: A write to the data word at 0x008 while the transmit queue holds 8 entries is dropped.
- R7: A read of the data word while the receive queue is empty returns 0 and leaves the status unchanged.
- R8: Each frame gives exactly frame-length rising serial clock edges, MSB first, with data-in sampled on the rising edge.
- R9: Every completed frame pushes one received word, right-justified and zero-filled above the frame length.
- R10: No frame starts while the receive queue is full; the waiting transmit word goes out once a word is popped.
- R11: Busy is high while a frame shifts or while the port is enabled with transmit data queued; chip select is low exactly while busy.
- R12: Bits [7:1] of the divisor word give the half period of the serial clock in bus clock cycles, with 0 treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 12 | Byte address, word aligned |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
The hardest state to reach is a full receive queue with transmit data still waiting. Busy must then stay high while no clock edge appears. The bench reaches it by loading eight words while the port is disabled, enabling it without reading, and pushing a ninth word once the first eight have landed. Then a single pop must release exactly one more frame. A mid-frame disable is forced by choosing a slow divisor and clearing the enable right after the first rising serial edge.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  // register word indices (byte address >> 2)
  localparam logic [9:0] IDX_CTRL  = 10'h000;
  localparam logic [9:0] IDX_EN    = 10'h001;
  localparam logic [9:0] IDX_DATA  = 10'h002;
  localparam logic [9:0] IDX_STAT  = 10'h003;
  localparam logic [9:0] IDX_DIV   = 10'h004;
  localparam logic [9:0] IDX_ID0   = 10'h3F8;
  localparam logic [9:0] IDX_ID1   = 10'h3F9;
  localparam logic [9:0] IDX_ID2   = 10'h3FA;
  localparam logic [9:0] IDX_ID3   = 10'h3FB;

  typedef struct packed {
    logic busy;
    logic rx_full;
    logic rx_nempty;
    logic tx_nfull;
    logic tx_empty;
  } stat_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rd_ptr];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W  = 16,
  localparam int IW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic [W-1:0]  data_i,
  input  logic [IW-1:0] last_i,
  input  logic [7:0]    half_i,
  input  logic          miso_i,
  output logic          active_o,
  output logic          done_o,
  output logic [W-1:0]  rx_o,
  output logic          sclk_o,
  output logic          mosi_o
);
  logic          active_q, sclk_q, done_q;
  logic [IW-1:0] idx_q;
  logic [7:0]    cnt_q;
  logic [W-1:0]  tx_sh, rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        active_q <= 1'b0;
        sclk_q   <= 1'b0;
      end else if (!active_q) begin
        if (start_i) begin
          active_q <= 1'b1;
          tx_sh    <= data_i;
          rx_sh    <= '0;
          idx_q    <= last_i;
          cnt_q    <= '0;
          sclk_q   <= 1'b0;
        end
      end else if (cnt_q == half_i - 8'd1) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
          rx_sh  <= {rx_sh[W-2:0], miso_i};
        end else begin
          sclk_q <= 1'b0;
          if (idx_q == '0) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
      end else begin
        cnt_q <= cnt_q + 8'd1;
      end
    end
  end

  assign active_o = active_q;
  assign done_o   = done_q;
  assign rx_o     = rx_sh;
  assign sclk_o   = sclk_q;
  assign mosi_o   = active_q ? tx_sh[idx_q] : 1'b0;
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
  import spi_master_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int IW   = $clog2(DW)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_sel_i,
  input  logic        bus_we_i,
  input  logic [11:0] bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        sclk_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        cs_n_o
);
  logic [IW-1:0] dss_q;
  logic          en_q;
  logic [7:0]    div_q;
  logic [9:0]    widx;
  logic          dr_wr, dr_rd;
  logic [DW-1:0] tx_head, rx_head, sh_rx;
  logic          tx_empty, tx_full, rx_empty, rx_full;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          sh_active, sh_done, sh_start, rx_pop;
  logic [IW-1:0] last_bit;
  logic [7:0]    half;
  logic          busy;
  stat_t         stat;

  assign widx  = bus_addr_i[11:2];
  assign dr_wr = bus_sel_i && bus_we_i  && (widx == IDX_DATA);
  assign dr_rd = bus_sel_i && !bus_we_i && (widx == IDX_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dss_q <= '0;
      en_q  <= 1'b0;
      div_q <= 8'd2;
    end else if (bus_sel_i && bus_we_i) begin
      case (widx)
        IDX_CTRL: dss_q <= bus_wdata_i[IW-1:0];
        IDX_EN:   en_q  <= bus_wdata_i[1];
        IDX_DIV:  div_q <= bus_wdata_i[7:0];
        default: ;
      endcase
    end
  end

  assign last_bit = (dss_q < IW'(3)) ? IW'(3) : dss_q;
  assign half     = (div_q[7:1] == 7'd0) ? 8'd1 : {1'b0, div_q[7:1]};
  // one idle cycle after each frame keeps the rx push ahead of the next start
  assign sh_start = en_q && !sh_active && !sh_done && !tx_empty && !rx_full;
  assign rx_pop   = dr_rd;
  assign busy     = sh_active || (en_q && !tx_empty);

  spi_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx (
    .clk_i, .rst_ni,
    .push_i (dr_wr),
    .data_i (bus_wdata_i[DW-1:0]),
    .pop_i  (sh_start),
    .data_o (tx_head),
    .empty_o(tx_empty),
    .full_o (tx_full),
    .cnt_o  (tx_cnt)
  );

  spi_fifo #(.W(DW), .DEPTH(DEPTH)) u_rx (
    .clk_i, .rst_ni,
    .push_i (sh_done),
    .data_i (sh_rx),
    .pop_i  (rx_pop),
    .data_o (rx_head),
    .empty_o(rx_empty),
    .full_o (rx_full),
    .cnt_o  (rx_cnt)
  );

  spi_shifter #(.W(DW)) u_sh (
    .clk_i, .rst_ni,
    .en_i    (en_q),
    .start_i (sh_start),
    .data_i  (tx_head),
    .last_i  (last_bit),
    .half_i  (half),
    .miso_i  (miso_i),
    .active_o(sh_active),
    .done_o  (sh_done),
    .rx_o    (sh_rx),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o)
  );

  always_comb begin
    stat.tx_empty  = tx_empty;
    stat.tx_nfull  = !tx_full;
    stat.rx_nempty = !rx_empty;
    stat.rx_full   = rx_full;
    stat.busy      = busy;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      case (widx)
        IDX_CTRL: bus_rdata_o = 32'(dss_q);
        IDX_EN:   bus_rdata_o = {30'd0, en_q, 1'b0};
        IDX_DATA: bus_rdata_o = rx_empty ? 32'd0 : 32'(rx_head);
        IDX_STAT: bus_rdata_o = 32'(stat);
        IDX_DIV:  bus_rdata_o = {24'd0, div_q};
        IDX_ID0:  bus_rdata_o = 32'h22;
        IDX_ID1:  bus_rdata_o = 32'h10;
        IDX_ID2:  bus_rdata_o = 32'h04;
        IDX_ID3:  bus_rdata_o = 32'h00;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign cs_n_o = !busy;
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_q,
  input logic          sclk_o,
  input logic          cs_n_o,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          sh_done,
  input logic          rx_pop,
  input logic          dr_rd,
  input logic          rx_empty,
  input logic [31:0]   bus_rdata_o
);
  p_no_clk_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !sclk_o);

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt <= CW'(DEPTH));

  p_rx_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt <= CW'(DEPTH));

  p_empty_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dr_rd && rx_empty) |-> (bus_rdata_o == 32'd0));

  p_frame_pushes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_done && !rx_pop) |=> (rx_cnt == $past(rx_cnt) + 1'b1));

  p_clk_under_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_n_o);
endmodule

bind spi_master_regs spi_master_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_q       (en_q),
  .sclk_o     (sclk_o),
  .cs_n_o     (cs_n_o),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .sh_done    (sh_done),
  .rx_pop     (rx_pop),
  .dr_rd      (dr_rd),
  .rx_empty   (rx_empty),
  .bus_rdata_o(bus_rdata_o)
);

// File: tb/sim_spi_master_regs.sv
module sim_spi_master_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, cs_n;
  logic        inv = 1'b0;
  logic        miso;

  int total = 0, fails = 0;
  int rises = 0;
  logic [15:0] expq [$];

  assign miso = mosi ^ inv;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge sclk) rises++;

  spi_master_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n)
  );

  function automatic logic [15:0] exp_rx(logic [15:0] d, int bits, logic iv);
    logic [31:0] m = (32'd1 << bits) - 32'd1;
    return 16'(({16'd0, d ^ {16{iv}}}) & m);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(12'h00C, s);
      if (!s[4]) break;
    end
  endtask

  task automatic drain(string req, int n);
    logic [31:0] d;
    for (int i = 0; i < n; i++) begin
      rd(12'h008, d);
      chk(req, d, {16'd0, expq.pop_front()});
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [15:0] w;
    int r0, bits, n, h;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1, R5 reset state
    rd(12'h00C, d); chk("R1 stat", d, 32'h3);
    rd(12'h000, d); chk("R1 ctrl", d, 0);
    rd(12'h004, d); chk("R1 en", d, 0);
    rd(12'h010, d); chk("R1 div", d, 2);
    chk("R11 cs idle", cs_n, 1);

    // R2 identification
    rd(12'hFE0, d); chk("R2 id0", d, 32'h22);
    rd(12'hFE4, d); chk("R2 id1", d, 32'h10);
    rd(12'hFE8, d); chk("R2 id2", d[3:0], 4);
    rd(12'hFEC, d); chk("R2 id3", d, 0);

    // R7 empty pop
    rd(12'h008, d); chk("R7 empty data", d, 0);
    rd(12'h00C, d); chk("R7 stat kept", d, 32'h3);

    // R4, R6 fill while disabled, ninth dropped
    wr(12'h000, 7);
    for (int i = 0; i < 9; i++) begin
      w = 16'($urandom());
      wr(12'h008, {16'd0, w});
      if (i < 8) expq.push_back(exp_rx(w, 8, 1'b0));
    end
    r0 = rises;
    repeat (50) @(negedge clk);
    chk("R4 no clock", rises - r0, 0);
    rd(12'h00C, d); chk("R6 R5 full tx stat", d, 32'h0);

    // enable: 8 frames into rx, R8
    wr(12'h004, 2);
    wait_idle();
    chk("R8 edge count", rises - r0, 64);
    rd(12'h00C, d); chk("R5 rx full stat", d, 32'hF);

    // R10 stall with rx full
    w = 16'h5A3C;
    wr(12'h008, {16'd0, w});
    expq.push_back(exp_rx(w, 8, 1'b0));
    r0 = rises;
    repeat (60) @(negedge clk);
    chk("R10 stalled", rises - r0, 0);
    rd(12'h00C, d); chk("R10 stall stat", d, 32'h1E);
    chk("R11 cs low busy", cs_n, 0);
    drain("R9 R6 data", 1);
    wait_idle();
    chk("R10 resumed", rises - r0, 8);
    drain("R9 data", 8);
    rd(12'h00C, d); chk("R6 nothing extra", d, 32'h3);
    chk("R11 cs released", cs_n, 1);

    // R3 short size field maps to 4 bits
    wr(12'h000, 1);
    r0 = rises;
    wr(12'h008, 32'hABCD);
    expq.push_back(16'hD);
    wait_idle();
    chk("R3 four edges", rises - r0, 4);
    drain("R3 data", 1);

    // R12 half period
    wr(12'h000, 15);
    wr(12'h010, 6);
    wr(12'h008, 32'h1234);
    expq.push_back(16'h1234);
    @(posedge sclk);
    h = 0;
    while (sclk) begin @(negedge clk); if (sclk) h++; end
    chk("R12 half period", h, 3);
    wait_idle();
    drain("R12 data", 1);

    // R4 abort mid-frame
    wr(12'h010, 80);
    wr(12'h008, 32'hFFFF);
    @(posedge sclk);
    wr(12'h004, 0);
    r0 = rises;
    repeat (200) @(negedge clk);
    chk("R4 abort clock", rises - r0, 0);
    chk("R4 abort sclk", sclk, 0);
    rd(12'h00C, d); chk("R4 abort stat", d, 32'h3);
    wr(12'h004, 2);

    // random frames, R8 R9
    for (int it = 0; it < 20; it++) begin
      bits = 4 + int'($urandom_range(12));
      n = 1 + int'($urandom_range(7));
      inv = 1'($urandom());
      wr(12'h000, bits - 1);
      wr(12'h010, 2 + $urandom_range(6));
      r0 = rises;
      for (int k = 0; k < n; k++) begin
        w = 16'($urandom());
        wr(12'h008, {16'd0, w});
        expq.push_back(exp_rx(w, bits, inv));
      end
      wait_idle();
      chk("R8 random edges", rises - r0, n * bits);
      drain("R9 random data", n);
    end

    finish_run();
  end
endmodule